// File: doc/BRIEF.md
# Dual-Mode MAC Transmit Serializer

This block sits at the PHY end of a MAC transmit path. It takes frame bytes from a valid/ready stream and drives a transmit-enable line and a 4-bit transmit-data bus. All of its logic runs on the transmit clock that the PHY supplies. In nibble mode each byte takes two clocks on the 4-bit bus. In serial encoder/decoder mode each byte takes eight clocks on data bit 0 alone, and the other three bus lines stay low. In both modes the lower-order part of the byte goes out first.

A single bit of a 32-bit MAC control word selects the mode. The block reads that bit only between frames, so a frame is never split across the two formats. While a frame is running, the stream is asked for its next byte during the last slot of the current byte. Consecutive bytes therefore leave without a gap. The stream is not asked for a new byte in the last slot of the byte that carries the end-of-frame marker.

Top module: `mac_tx_serializer`

## Requirements
- R1: While reset is asserted and just after it is released, phy_tx_en_o is 0, phy_txd_o is 0 and tx_ready_o is 1.
- R2: Bit 27 of mac_ctrl_i selects the mode: 1 means serial mode and 0 means nibble mode. All other bits of mac_ctrl_i have no effect.
- R3: In nibble mode a byte b goes out on two consecutive clocks, first as b[3:0] and then as b[7:4]. For example, A1h is sent as 1h then Ah.
- R4: In serial mode a byte b goes out on eight consecutive clocks as b[0], b[1], …, b[7] on phy_txd_o[0]. phy_txd_o[3:1] stays 0 during these clocks.
- R5: A byte accepted at a clock edge is on phy_txd_o, with phy_tx_en_o high, from that same edge onward. phy_tx_en_o goes low on the edge after the last slot of the frame. phy_txd_o is 0 whenever phy_tx_en_o is low.
- R6: tx_ready_o is 1 whenever the block is idle. Within a frame it is 1 only in the last slot of a byte, so the next byte is accepted 2 clocks (nibble) or 8 clocks (serial) after the previous one, with no gap on phy_tx_en_o.
- R7: A change of bit 27 made while phy_tx_en_o is high has no effect on the frame in progress. It applies from the next frame onward.
- R8: After the byte with tx_last_i set is accepted, tx_ready_o stays 0 for all of that byte's slots. It returns to 1 only once phy_tx_en_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Transmit clock from the PHY |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mac_ctrl_i | input | 32 | MAC control word; bit 27 selects the mode |
| tx_data_i | input | 8 | Byte to transmit |
| tx_valid_i | input | 1 | tx_data_i holds a byte |
| tx_last_i | input | 1 | This byte ends the frame |
| tx_ready_o | output | 1 | The byte is taken at this clock edge |
| phy_tx_en_o | output | 1 | Transmit enable to the PHY |
| phy_txd_o | output | 4 | Transmit data to the PHY |

## Verification
A slot counter that slips, or a shift register that drops or repeats bits, shows up on phy_txd_o within the same byte, one to eight clocks after the byte is accepted. It also changes the spacing between accepts on tx_ready_o by the next byte. If the frame-end flag or the enable register is corrupted, phy_tx_en_o either stays high past the last slot or drops in the middle of a frame. This shows up in the slot count and the number of enable rises per frame. If the mode register is latched at the wrong time, bits 3:1 appear nonzero in serial mode, or the byte length changes in the middle of a frame, within one byte time.

// File: rtl/txser_pkg.sv
package txser_pkg;
  typedef enum logic {
    MODE_NIBBLE = 1'b0,
    MODE_SERIAL = 1'b1
  } tx_mode_e;
endpackage

// File: rtl/txser_mode_latch.sv
module txser_mode_latch
  import txser_pkg::*;
#(
  parameter int CTRL_W   = 32,
  parameter int MODE_BIT = 27
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic              busy_i,
  output tx_mode_e          mode_o
);
  tx_mode_e mode_q;
  tx_mode_e mode_req;
  logic     unused_ctrl;

  assign mode_req    = tx_mode_e'(ctrl_i[MODE_BIT]);
  assign unused_ctrl = ^(ctrl_i & ~(CTRL_W'(1) << MODE_BIT));

  // track the request only between frames
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mode_q <= MODE_NIBBLE;
    else if (!busy_i) mode_q <= mode_req;
  end

  assign mode_o = busy_i ? mode_q : mode_req;
endmodule

// File: rtl/txser_slot_ctrl.sv
module txser_slot_ctrl
  import txser_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int NIB_W  = 4
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  tx_mode_e mode_i,
  input  logic     valid_i,
  input  logic     last_i,
  output logic     ready_o,
  output logic     load_o,
  output logic     step_o,
  output logic     stop_o,
  output logic     busy_o
);
  localparam int NIB_SLOTS = BYTE_W / NIB_W;
  localparam int SER_SLOTS = BYTE_W;
  localparam int CNT_W     = (SER_SLOTS > 1) ? $clog2(SER_SLOTS) : 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] end_slot;
  logic             busy_q;
  logic             last_q;
  logic             at_end;

  assign end_slot = (mode_i == MODE_SERIAL) ? CNT_W'(SER_SLOTS - 1) : CNT_W'(NIB_SLOTS - 1);
  assign at_end   = busy_q && (cnt_q == end_slot);
  // look-ahead: the next byte is taken in the final slot of the current one
  assign ready_o  = !busy_q || (at_end && !last_q);
  assign load_o   = valid_i && ready_o;
  assign step_o   = busy_q && !at_end;
  assign stop_o   = at_end && !load_o;
  assign busy_o   = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      last_q <= 1'b0;
      cnt_q  <= '0;
    end else if (load_o) begin
      busy_q <= 1'b1;
      last_q <= last_i;
      cnt_q  <= '0;
    end else if (step_o) begin
      cnt_q  <= cnt_q + CNT_W'(1);
    end else if (stop_o) begin
      busy_q <= 1'b0;
      last_q <= 1'b0;
      cnt_q  <= '0;
    end
  end
endmodule

// File: rtl/txser_shifter.sv
module txser_shifter
  import txser_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int NIB_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  tx_mode_e          mode_i,
  input  logic              load_i,
  input  logic              step_i,
  input  logic              stop_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic [NIB_W-1:0]  txd_o
);
  logic [BYTE_W-1:0] sh_q;
  logic [BYTE_W-1:0] src;
  logic [BYTE_W-1:0] rest;
  logic [NIB_W-1:0]  slot;
  logic [NIB_W-1:0]  txd_q;

  always_comb begin
    src = load_i ? data_i : sh_q;
    if (mode_i == MODE_SERIAL) begin
      slot = {{(NIB_W-1){1'b0}}, src[0]};
      rest = src >> 1;
    end else begin
      slot = src[NIB_W-1:0];
      rest = src >> NIB_W;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      txd_q <= '0;
    end else if (load_i || step_i) begin
      sh_q  <= rest;
      txd_q <= slot;
    end else if (stop_i) begin
      sh_q  <= '0;
      txd_q <= '0;
    end
  end

  assign txd_o = txd_q;
endmodule

// File: rtl/mac_tx_serializer.sv
module mac_tx_serializer
  import txser_pkg::*;
#(
  parameter int CTRL_W   = 32,
  parameter int MODE_BIT = 27,
  parameter int BYTE_W   = 8,
  parameter int NIB_W    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CTRL_W-1:0] mac_ctrl_i,
  input  logic [BYTE_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  input  logic              tx_last_i,
  output logic              tx_ready_o,
  output logic              phy_tx_en_o,
  output logic [NIB_W-1:0]  phy_txd_o
);
  tx_mode_e mode;
  logic     busy;
  logic     load;
  logic     step;
  logic     stop;

  txser_mode_latch #(.CTRL_W(CTRL_W), .MODE_BIT(MODE_BIT)) u_mode (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ctrl_i(mac_ctrl_i),
    .busy_i(busy),
    .mode_o(mode)
  );

  txser_slot_ctrl #(.BYTE_W(BYTE_W), .NIB_W(NIB_W)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (mode),
    .valid_i(tx_valid_i),
    .last_i (tx_last_i),
    .ready_o(tx_ready_o),
    .load_o (load),
    .step_o (step),
    .stop_o (stop),
    .busy_o (busy)
  );

  txser_shifter #(.BYTE_W(BYTE_W), .NIB_W(NIB_W)) u_shift (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .mode_i(mode),
    .load_i(load),
    .step_i(step),
    .stop_i(stop),
    .data_i(tx_data_i),
    .txd_o (phy_txd_o)
  );

  assign phy_tx_en_o = busy;
endmodule

// File: rtl/mac_tx_serializer_chk.sv
module mac_tx_serializer_chk
  import txser_pkg::*;
#(
  parameter int NIB_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tx_valid_i,
  input logic             tx_ready_o,
  input logic             phy_tx_en_o,
  input logic [NIB_W-1:0] phy_txd_o,
  input tx_mode_e         mode_i
);
  AST_IDLE_TXD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !phy_tx_en_o |-> phy_txd_o == '0); // R5

  AST_ACCEPT_STARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_i && tx_ready_o) |=> phy_tx_en_o); // R5

  AST_SERIAL_UPPER_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phy_tx_en_o && mode_i == MODE_SERIAL) |-> phy_txd_o[NIB_W-1:1] == '0); // R4

  AST_SERIAL_MIN_SPAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(phy_tx_en_o) && mode_i == MODE_SERIAL) |=> phy_tx_en_o); // R4

  AST_IDLE_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !phy_tx_en_o |-> tx_ready_o); // R6

  AST_MODE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phy_tx_en_o && $past(phy_tx_en_o)) |-> $stable(mode_i)); // R7
endmodule

bind mac_tx_serializer mac_tx_serializer_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tx_valid_i (tx_valid_i),
  .tx_ready_o (tx_ready_o),
  .phy_tx_en_o(phy_tx_en_o),
  .phy_txd_o  (phy_txd_o),
  .mode_i     (mode)
);

// File: tb/sim_mac_tx_serializer.sv
`timescale 1ns/1ps
module sim_mac_tx_serializer;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] mac_ctrl = '0;
  logic [7:0]  tx_data = '0;
  logic        tx_valid = 1'b0;
  logic        tx_last = 1'b0;
  logic        tx_ready;
  logic        tx_en;
  logic [3:0]  txd;

  int n_chk = 0;
  int n_bad = 0;

  logic [3:0]  cap [0:255];
  int          ncap = 0;
  int          nrise = 0;
  logic        prev_en = 1'b0;
  logic [7:0]  fb [0:15];

  localparam logic [31:0] SER = 32'h0800_0000;
  localparam logic [31:0] NIB = 32'h0000_0000;

  always #2.5 clk = ~clk;

  mac_tx_serializer u0 (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .mac_ctrl_i (mac_ctrl),
    .tx_data_i  (tx_data),
    .tx_valid_i (tx_valid),
    .tx_last_i  (tx_last),
    .tx_ready_o (tx_ready),
    .phy_tx_en_o(tx_en),
    .phy_txd_o  (txd)
  );

  always @(negedge clk) begin
    if (tx_en) begin
      if (ncap < 256) cap[ncap] = txd;
      ncap = ncap + 1;
      if (!prev_en) nrise = nrise + 1;
    end
    prev_en = tx_en;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // sends fb[0..n-1]; ctrl_mid is applied right after the first accept
  task automatic run_frame(input logic [31:0] ctrl, input logic [31:0] ctrl_mid,
                           input int n, input bit exp_ser, input string rq);
    int spb;
    int waits;
    logic [3:0] e;
    spb = exp_ser ? 8 : 2;
    @(negedge clk);
    mac_ctrl = ctrl;
    ncap = 0;
    nrise = 0;
    for (int i = 0; i < n; i++) begin
      tx_data  = fb[i];
      tx_valid = 1'b1;
      tx_last  = (i == n - 1);
      waits = 0;
      while (!tx_ready) begin
        @(negedge clk);
        waits++;
      end
      if (i > 0) check(waits == spb - 1, "R6 byte spacing", waits, spb - 1);
      @(posedge clk);
      @(negedge clk);
      if (i == 0) begin
        e = exp_ser ? {3'b000, fb[0][0]} : fb[0][3:0];
        check(tx_en == 1'b1, "R5 enable with first slot", tx_en, 1);
        check(txd == e, "R5 first slot data", txd, e);
        mac_ctrl = ctrl_mid;
      end
    end
    tx_valid = 1'b0;
    tx_last  = 1'b0;
    waits = 0;
    while (!tx_ready) begin
      @(negedge clk);
      waits++;
    end
    check(waits == spb, "R8 ready held through last byte", waits, spb);
    check(tx_en == 1'b0, "R5 enable low after last slot", tx_en, 0);
    check(ncap == n * spb, {rq, " slot count"}, ncap, n * spb);
    check(nrise == 1, "R6 no gap inside frame", nrise, 1);
    for (int i = 0; i < n; i++) begin
      for (int k = 0; k < spb; k++) begin
        if (exp_ser) e = {3'b000, fb[i][k]};
        else         e = (k == 0) ? fb[i][3:0] : fb[i][7:4];
        check(cap[i * spb + k] == e, {rq, " slot data"}, cap[i * spb + k], e);
      end
    end
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(tx_en == 1'b0, "R1 enable in reset", tx_en, 0);
    check(txd == 4'h0, "R1 data in reset", txd, 0);
    check(tx_ready == 1'b1, "R1 ready in reset", tx_ready, 1);
    rst_ni = 1'b1;
    @(negedge clk);
    check(tx_en == 1'b0 && txd == 4'h0, "R1 idle after reset", {tx_en, txd}, 0);
  endtask

  task automatic t_nibble();
    fb[0] = 8'hA1; fb[1] = 8'hE6; fb[2] = 8'h5C;
    run_frame(NIB, NIB, 3, 1'b0, "R3 nibble");
  endtask

  task automatic t_serial();
    fb[0] = 8'hA1; fb[1] = 8'hE6;
    run_frame(SER, SER, 2, 1'b1, "R4 serial");
  endtask

  task automatic t_ctrl_other_bits();
    fb[0] = 8'h3F;
    run_frame(32'hF7FF_FFFF, 32'hF7FF_FFFF, 1, 1'b0, "R2 nibble with other bits set");
    fb[0] = 8'h96;
    run_frame(32'h0800_0000, 32'h0800_0000, 1, 1'b1, "R2 serial with bit 27");
  endtask

  task automatic t_mode_change();
    fb[0] = 8'h81; fb[1] = 8'h7E; fb[2] = 8'h33;
    run_frame(SER, NIB, 3, 1'b1, "R7 serial held");
    fb[0] = 8'hC4; fb[1] = 8'h2B;
    run_frame(NIB, SER, 2, 1'b0, "R7 nibble held");
    fb[0] = 8'h55;
    run_frame(SER, SER, 1, 1'b1, "R7 change applied next frame");
  endtask

  task automatic t_no_valid();
    repeat (5) @(negedge clk);
    check(tx_en == 1'b0, "R6 idle without valid", tx_en, 0);
    check(tx_ready == 1'b1, "R6 ready while idle", tx_ready, 1);
  endtask

  initial begin
    t_reset();
    t_nibble();
    t_serial();
    t_ctrl_other_bits();
    t_mode_change();
    t_no_valid();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule